// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block manages the state changes a simple processor core makes when it takes an interrupt and when it returns from one. It holds a machine status word and two save registers. One save register keeps the resume address and the other keeps the saved status word. The pipeline steps the block only at instruction boundaries, so an event is never taken in the middle of an instruction.

At each boundary the block picks at most one event. The candidates are a non-maskable reset request, a synchronous exception with its type code, the external interrupt line (gated by the enable bit in the status word), and the return-from-interrupt strobe.

On entry the block saves the next instruction address and the status word, clears the enable bit in the same cycle, and issues a redirect to a handler address. The type of event picks that address; the program does not. On return it restores the status word from the save register and redirects to the saved address.

There is no stack. A second entry taken before software copies the save registers out overwrites them.

Top module: `trap_sequencer`

## Requirements
- R1: After reset, `msr_o` equals `MSR_RST` (default 0x0001_0002, enable bit set), both save registers read 0, `redirect_o` is 0 and `cause_o` is 0 (none).
- R2: While `boundary_i` is 0, every request input and the status write port are ignored: no redirect occurs and `msr_o`, `save_pc_o` and `save_msr_o` keep their values.
- R3: On entry, in one clock edge, `save_pc_o` takes `next_pc_i`, `save_msr_o` takes the old status word, and `msr_o` becomes the old word with bit `EE_BIT` (default 16) cleared and every other bit kept.
- R4: An entry redirects to `VEC_BASE + (type << 8)` (default base 0x0001_0000). The type is `exc_type_i` for an exception, `RST_TYPE` (1) for reset and `EXT_TYPE` (5) for the external line. `redirect_o` is high for one cycle.
- R5: The external line is ignored when status bit `EE_BIT` is 0. It causes an entry with cause 3 when that bit is 1.
- R6: A reset request at a boundary causes an entry with cause 1, whatever the value of the enable bit.
- R7: When several events meet at one boundary, reset beats the exception, the exception beats the external line, and any entry beats a return. The exception's cause code is 2.
- R8: A return with no competing entry loads `msr_o` from `save_msr_o`, redirects to `save_pc_o` with cause 4, and leaves both save registers unchanged.
- R9: A second entry before software copies the save registers out overwrites both of them, and the following return goes to the newer context.
- R10: At a boundary with no entry and no return, `msr_we_i` loads `msr_wdata_i` into the status word. When an entry or return falls on the same boundary, the write is dropped.

Cause codes on `cause_o`: 0 none, 1 reset, 2 exception, 3 external, 4 return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the block |
| boundary_i | input | 1 | High when the current cycle is an instruction boundary |
| next_pc_i | input | ADDR_W | Address of the next instruction |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_type_i | input | TYPE_W | Exception type code |
| ext_irq_i | input | 1 | Maskable external interrupt line |
| rst_req_i | input | 1 | Non-maskable reset request |
| rfi_i | input | 1 | Return-from-interrupt strobe |
| msr_we_i | input | 1 | Status word write enable |
| msr_wdata_i | input | MSR_W | Status word write data |
| redirect_o | output | 1 | One-cycle redirect pulse |
| redirect_pc_o | output | ADDR_W | Redirect target, valid while `redirect_o` is high |
| cause_o | output | 3 | Event taken at the last boundary |
| msr_o | output | MSR_W | Machine status word |
| save_pc_o | output | ADDR_W | Saved resume address |
| save_msr_o | output | MSR_W | Saved status word |

## Verification
Every result is registered: inputs sampled at a boundary edge show on the redirect, cause, status and save outputs right after that same edge, one cycle later, and on no later cycle. The driver sets inputs on the falling edge. After the next rising edge it pushes the values expected for that edge, taken from a model of the requirements. The monitor pops and compares them on the following falling edge, so each item lands on the exact cycle its result is due. Idle cycles and non-boundary cycles also push items, which shows that requests off a boundary leave the state unchanged.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_RST  = 3'd1,
    EV_EXC  = 3'd2,
    EV_EXT  = 3'd3,
    EV_RFI  = 3'd4
  } ev_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_seq_pkg::*;
#(
  parameter int unsigned TYPE_W   = 4,
  parameter int unsigned RST_TYPE = 1,
  parameter int unsigned EXT_TYPE = 5
) (
  input  logic              boundary_i,
  input  logic              rst_req_i,
  input  logic              exc_req_i,
  input  logic [TYPE_W-1:0] exc_type_i,
  input  logic              ext_irq_i,
  input  logic              ee_i,
  input  logic              rfi_i,
  output ev_e               ev_o,
  output logic [TYPE_W-1:0] type_o
);
  localparam logic [TYPE_W-1:0] RstCode = TYPE_W'(RST_TYPE);
  localparam logic [TYPE_W-1:0] ExtCode = TYPE_W'(EXT_TYPE);

  // fixed priority: reset, exception, masked external, return
  always_comb begin
    ev_o   = EV_NONE;
    type_o = '0;
    if (boundary_i) begin
      if (rst_req_i) begin
        ev_o   = EV_RST;
        type_o = RstCode;
      end else if (exc_req_i) begin
        ev_o   = EV_EXC;
        type_o = exc_type_i;
      end else if (ext_irq_i && ee_i) begin
        ev_o   = EV_EXT;
        type_o = ExtCode;
      end else if (rfi_i) begin
        ev_o   = EV_RFI;
      end
    end
  end
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       TYPE_W    = 4,
  parameter int unsigned       VEC_SHIFT = 8,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 32'h0001_0000
) (
  input  logic [TYPE_W-1:0] type_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned SpanW = TYPE_W + VEC_SHIFT;

  generate
    if (SpanW <= ADDR_W) begin : g_fit
      assign addr_o = VEC_BASE + (ADDR_W'(type_i) << VEC_SHIFT);
    end else begin : g_trunc
      logic [SpanW-1:0] off;
      assign off    = SpanW'(type_i) << VEC_SHIFT;
      assign addr_o = VEC_BASE + off[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
  import trap_seq_pkg::*;
#(
  parameter int unsigned      ADDR_W  = 32,
  parameter int unsigned      MSR_W   = 32,
  parameter int unsigned      EE_BIT  = 16,
  parameter logic [MSR_W-1:0] MSR_RST = 32'h0001_0002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ev_e               ev_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic              msr_we_i,
  input  logic [MSR_W-1:0]  msr_wdata_i,
  output logic [MSR_W-1:0]  msr_o,
  output logic [ADDR_W-1:0] save_pc_o,
  output logic [MSR_W-1:0]  save_msr_o
);
  localparam logic [MSR_W-1:0] EeMask = MSR_W'(1) << EE_BIT;

  logic             entry;
  logic [MSR_W-1:0] msr_q, save_msr_q;
  logic [ADDR_W-1:0] save_pc_q;

  assign entry = (ev_i == EV_RST) || (ev_i == EV_EXC) || (ev_i == EV_EXT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msr_q      <= MSR_RST;
      save_pc_q  <= '0;
      save_msr_q <= '0;
    end else if (entry) begin
      save_pc_q  <= next_pc_i;
      save_msr_q <= msr_q;
      msr_q      <= msr_q & ~EeMask;
    end else if (ev_i == EV_RFI) begin
      msr_q <= save_msr_q;
    end else if (msr_we_i) begin
      // the arbiter reports EV_NONE off boundary; write gated by top
      msr_q <= msr_wdata_i;
    end
  end

  assign msr_o      = msr_q;
  assign save_pc_o  = save_pc_q;
  assign save_msr_o = save_msr_q;

  assert_ee_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |=> !msr_q[EE_BIT] && (save_msr_q == $past(msr_q)));
  assert_save_pc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |=> save_pc_q == $past(next_pc_i));
  assert_rfi_restore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_RFI) |=> (msr_q == $past(save_msr_q)) && $stable(save_pc_q)
                         && $stable(save_msr_q));
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       MSR_W     = 32,
  parameter int unsigned       TYPE_W    = 4,
  parameter int unsigned       EE_BIT    = 16,
  parameter int unsigned       VEC_SHIFT = 8,
  parameter int unsigned       RST_TYPE  = 1,
  parameter int unsigned       EXT_TYPE  = 5,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 32'h0001_0000,
  parameter logic [MSR_W-1:0]  MSR_RST   = 32'h0001_0002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic              exc_req_i,
  input  logic [TYPE_W-1:0] exc_type_i,
  input  logic              ext_irq_i,
  input  logic              rst_req_i,
  input  logic              rfi_i,
  input  logic              msr_we_i,
  input  logic [MSR_W-1:0]  msr_wdata_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic [2:0]        cause_o,
  output logic [MSR_W-1:0]  msr_o,
  output logic [ADDR_W-1:0] save_pc_o,
  output logic [MSR_W-1:0]  save_msr_o
);
  ev_e               ev;
  logic [TYPE_W-1:0] ev_type;
  logic [ADDR_W-1:0] vec_addr;
  logic              take;
  logic              redirect_q;
  logic [ADDR_W-1:0] redirect_pc_q;
  ev_e               cause_q;

  trap_arbiter #(
    .TYPE_W(TYPE_W), .RST_TYPE(RST_TYPE), .EXT_TYPE(EXT_TYPE)
  ) u_arb (
    .boundary_i (boundary_i),
    .rst_req_i  (rst_req_i),
    .exc_req_i  (exc_req_i),
    .exc_type_i (exc_type_i),
    .ext_irq_i  (ext_irq_i),
    .ee_i       (msr_o[EE_BIT]),
    .rfi_i      (rfi_i),
    .ev_o       (ev),
    .type_o     (ev_type)
  );

  trap_vector_gen #(
    .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .VEC_SHIFT(VEC_SHIFT), .VEC_BASE(VEC_BASE)
  ) u_vec (
    .type_i (ev_type),
    .addr_o (vec_addr)
  );

  trap_state_regs #(
    .ADDR_W(ADDR_W), .MSR_W(MSR_W), .EE_BIT(EE_BIT), .MSR_RST(MSR_RST)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_i        (ev),
    .next_pc_i   (next_pc_i),
    .msr_we_i    (msr_we_i && boundary_i),
    .msr_wdata_i (msr_wdata_i),
    .msr_o       (msr_o),
    .save_pc_o   (save_pc_o),
    .save_msr_o  (save_msr_o)
  );

  assign take = (ev != EV_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_q    <= 1'b0;
      redirect_pc_q <= '0;
      cause_q       <= EV_NONE;
    end else begin
      redirect_q <= take;
      cause_q    <= ev;
      if (take) redirect_pc_q <= (ev == EV_RFI) ? save_pc_o : vec_addr;
    end
  end

  assign redirect_o    = redirect_q;
  assign redirect_pc_o = redirect_pc_q;
  assign cause_o       = cause_q;

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> !redirect_o && $stable(msr_o) && $stable(save_pc_o)
                    && $stable(save_msr_o));
  assert_vec_align_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && cause_o != 3'(EV_RFI)) |->
      redirect_pc_o[VEC_SHIFT-1:0] == VEC_BASE[VEC_SHIFT-1:0]);
  assert_ext_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && ext_irq_i && !msr_o[EE_BIT] && !rst_req_i && !exc_req_i)
      |=> cause_o != 3'(EV_EXT));
  assert_rst_taken_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && rst_req_i) |=> redirect_o && cause_o == 3'(EV_RST));
  assert_exc_over_ext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && exc_req_i && !rst_req_i) |=> cause_o == 3'(EV_EXC));
endmodule

// File: tb/trap_sequencer_bench.sv
module trap_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EE_BIT     = 16;
  localparam logic [31:0] VEC_BASE = 32'h0001_0000;
  localparam logic [31:0] MSR_RST  = 32'h0001_0002;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        boundary, exc_req, ext_irq, rst_req, rfi, msr_we;
  logic [3:0]  exc_type;
  logic [31:0] next_pc, msr_wdata;
  logic        redirect;
  logic [31:0] redirect_pc, msr, save_pc, save_msr;
  logic [2:0]  cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        redir;
    logic [31:0] pc;
    logic [2:0]  cause;
    logic [31:0] msr;
    logic [31:0] spc;
    logic [31:0] smsr;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [31:0] m_msr, m_spc, m_smsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_sequencer u_trap_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .boundary_i(boundary), .next_pc_i(next_pc),
    .exc_req_i(exc_req), .exc_type_i(exc_type), .ext_irq_i(ext_irq),
    .rst_req_i(rst_req), .rfi_i(rfi), .msr_we_i(msr_we), .msr_wdata_i(msr_wdata),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc), .cause_o(cause),
    .msr_o(msr), .save_pc_o(save_pc), .save_msr_o(save_msr)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compare one expected item per cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "redirect", 32'(redirect), 32'(e.redir));
      chk(e.tag, "cause", 32'(cause), 32'(e.cause));
      if (e.redir) chk(e.tag, "target", redirect_pc, e.pc);
      chk(e.tag, "msr", msr, e.msr);
      chk(e.tag, "save_pc", save_pc, e.spc);
      chk(e.tag, "save_msr", save_msr, e.smsr);
    end
  end

  // driver: apply one cycle and push what the requirements predict
  task automatic step(bit bnd, bit rr, bit ex, logic [3:0] et, bit ei, logic [31:0] pc,
                      bit rt, bit we, logic [31:0] wd, string tag);
    exp_t e;
    logic [2:0] ev;
    logic [3:0] ty;
    @(negedge clk);
    boundary = bnd; rst_req = rr; exc_req = ex; exc_type = et; ext_irq = ei;
    next_pc = pc; rfi = rt; msr_we = we; msr_wdata = wd;
    ev = 3'd0; ty = 4'd0;
    if (bnd) begin
      if (rr)                       begin ev = 3'd1; ty = 4'd1; end
      else if (ex)                  begin ev = 3'd2; ty = et;   end
      else if (ei && m_msr[EE_BIT]) begin ev = 3'd3; ty = 4'd5; end
      else if (rt)                        ev = 3'd4;
    end
    e.redir = (ev != 3'd0);
    e.cause = ev;
    e.pc    = 32'h0;
    if (ev inside {3'd1, 3'd2, 3'd3}) begin
      e.pc   = VEC_BASE + (32'(ty) << 8);
      m_smsr = m_msr;
      m_spc  = pc;
      m_msr  = m_msr & ~(32'h1 << EE_BIT);
    end else if (ev == 3'd4) begin
      e.pc  = m_spc;
      m_msr = m_smsr;
    end else if (bnd && we) begin
      m_msr = wd;
    end
    e.msr = m_msr; e.spc = m_spc; e.smsr = m_smsr; e.tag = tag;
    @(posedge clk);
    #1 exp_q.push_back(e);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    boundary = 0; rst_req = 0; exc_req = 0; exc_type = 0; ext_irq = 0;
    next_pc = 0; rfi = 0; msr_we = 0; msr_wdata = 0;
    m_msr = MSR_RST; m_spc = 0; m_smsr = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "redirect", 32'(redirect), 32'h0);
    chk("R1", "cause", 32'(cause), 32'h0);
    chk("R1", "msr", msr, MSR_RST);
    chk("R1", "save_pc", save_pc, 32'h0);
    chk("R1", "save_msr", save_msr, 32'h0);

    // R2 everything asserted off a boundary: nothing happens
    step(0, 1, 1, 4'h3, 1, 32'h0000_0400, 1, 1, 32'h0, "R2");
    step(0, 0, 0, 4'h0, 1, 32'h0000_0404, 1, 0, 32'h0, "R2");
    // R10 status write with EE cleared
    step(1, 0, 0, 4'h0, 0, 32'h0000_0408, 0, 1, 32'h0000_0082, "R10");
    // R5 external line masked
    step(1, 0, 0, 4'h0, 1, 32'h0000_040C, 0, 0, 32'h0, "R5");
    // R6 reset taken while masked; R3 save, R4 vector
    step(1, 1, 0, 4'h0, 1, 32'h0000_0410, 0, 0, 32'h0, "R6");
    step(0, 0, 0, 4'h0, 0, 32'h0, 0, 0, 32'h0, "R4");
    // R8 return restores status and goes to saved address
    step(1, 0, 0, 4'h0, 0, 32'h0001_01FC, 1, 0, 32'h0, "R8");
    // R10 enable external
    step(1, 0, 0, 4'h0, 0, 32'h0000_0410, 0, 1, 32'h0001_0082, "R10");
    // R5 external taken when enabled; R3 bit 16 cleared, others kept
    step(1, 0, 0, 4'h0, 1, 32'h0000_2000, 0, 0, 32'h0, "R5");
    step(1, 0, 0, 4'h0, 0, 32'h0001_0504, 1, 0, 32'h0, "R8");
    // R7 exception wins over enabled external
    step(1, 0, 1, 4'h3, 1, 32'h0000_3000, 0, 0, 32'h0, "R7");
    // R9 nested entry overwrites save registers
    step(1, 0, 1, 4'hC, 0, 32'h0001_0320, 0, 0, 32'h0, "R9");
    step(1, 0, 0, 4'h0, 0, 32'h0001_0C08, 1, 0, 32'h0, "R9");
    // R7 reset wins over exception
    step(1, 1, 1, 4'h7, 1, 32'h0000_4000, 0, 0, 32'h0, "R7");
    // R10 write dropped when entry shares the boundary
    step(1, 0, 1, 4'h2, 0, 32'h0000_5000, 0, 1, 32'hFFFF_FFFF, "R10");
    // R4 largest type code
    step(1, 0, 1, 4'hF, 0, 32'h0000_6000, 0, 0, 32'h0, "R4");
    // R7 exception wins over return
    step(1, 0, 1, 4'h1, 0, 32'h0000_7000, 1, 0, 32'h0, "R7");
    step(1, 0, 0, 4'h0, 0, 32'h0001_0104, 1, 0, 32'h0, "R8");
    step(0, 0, 0, 4'h0, 0, 32'h0, 0, 0, 32'h0, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule